// File: doc/BRIEF.md
# Interrupt Arbitration and Break Injection Unit

This unit sits beside a cycle-stepped CPU sequencer. At every instruction boundary it decides whether an interrupt sequence begins. It watches a level-sensitive maskable request, an edge-triggered non-maskable request, a reset request and the interrupt-disable flag. It also watches three sequencer strobes: the opcode-fetch cycle (`sync_i`), the final cycle of an instruction (`last_cycle_i`) and a conditional-branch indicator.

When an interrupt is taken, the unit tells the sequencer to discard the opcode it has just fetched and run the break entry sequence in its place. It presents a 2-bit vector-select code and a flag that marks the break as hardware-initiated. The sequencer uses that flag to push a status byte with the break bit cleared.

The unit does not perform the stack pushes or the vector fetch. It only decides when a sequence starts and which vector the sequence finishes with.

Requests are sampled in a window that closes one cycle before the last cycle of an instruction. For conditional branches the window closes in the last cycle itself. A maskable entry that is still early in its sequence can be redirected to the non-maskable vector.

Top module: `intr_inject_unit`

## Requirements
- R1: After `rst_n` is released, outputs stay idle (`force_brk_o`=0, `hw_brk_o`=0, `vec_sel_o`=0) until the first cycle with `sync_i`=1. In that cycle `force_brk_o`=1 and `vec_sel_o`=3 (reset code).
- R2: An entry lasts 7 cycles: the forced fetch cycle plus 6 more. During all 7 cycles `hw_brk_o`=1 and `vec_sel_o` keeps its code, except as R11 allows. Afterwards `vec_sel_o`=0 and `hw_brk_o`=0.
- R3: A `sync_i` cycle with no pending request gives `force_brk_o`=0, `hw_brk_o`=0 and `vec_sel_o`=0.
- R4: If `irq_n_i` is low with `irq_mask_i`=0 in the cycle before the last cycle of a non-branch instruction, the next `sync_i` cycle forces a break with `vec_sel_o`=1 (maskable code).
- R5: With `irq_mask_i`=1, a low `irq_n_i` never forces a break.
- R6: A maskable request first present in the last cycle of a non-branch instruction is not taken at that boundary. If it is still held, it is taken at the end of the following instruction.
- R7: When `branch_i`=1, a request present only in the last cycle is taken at the next boundary.
- R8: A falling edge on `nmi_n_i` is latched, even if the pulse lasts one cycle. It is taken regardless of `irq_mask_i`, with `vec_sel_o`=2 (non-maskable code).
- R9: A latched non-maskable request is consumed when its code is selected. Holding `nmi_n_i` low does not start a second entry.
- R10: When several requests meet at one boundary, reset (3) wins over non-maskable (2), which wins over maskable (1).
- R11: A `nmi_n_i` falling edge during entry cycles 1 to 4 of a maskable entry (the forced cycle is cycle 0) switches `vec_sel_o` from 1 to 2 in the next cycle and consumes the request. An edge in entry cycles 5 or 6 leaves code 1, and the request is taken at the next boundary.
- R12: A one-cycle pulse on `cpu_reset_req_i` anywhere in an instruction forces a break with `vec_sel_o`=3 at the next `sync_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the unit; arms a reset entry |
| cpu_reset_req_i | input | 1 | Active-high reset request from the system |
| irq_n_i | input | 1 | Maskable request, active-low level |
| nmi_n_i | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_mask_i | input | 1 | Interrupt-disable flag from the status register |
| sync_i | input | 1 | Sequencer is in an opcode-fetch cycle |
| last_cycle_i | input | 1 | Sequencer is in the final cycle of an instruction |
| branch_i | input | 1 | Current instruction is a conditional branch |
| force_brk_o | output | 1 | Discard the fetched opcode and substitute the break opcode |
| vec_sel_o | output | 2 | 0 none, 1 maskable/break, 2 non-maskable, 3 reset |
| hw_brk_o | output | 1 | The running break is hardware-initiated (pushed break bit cleared) |

## Verification
A wrong sampling-window state shows at the very next `sync_i` cycle. It appears as an entry that starts one instruction early or late, or as a missing or spurious `force_brk_o`. A lost or stuck non-maskable latch shows either as an edge that never produces code 2, or as a second entry at the following boundary.

A wrong entry counter shows as a `hw_brk_o` window that is not exactly 7 cycles. It can also show as a hijack accepted or refused at the cycle-4/5 boundary, seen in `vec_sel_o` one cycle after the edge. The bench therefore checks every cycle of each entry rather than only its start.

// File: rtl/intr_pkg.sv
// Shared types for the interrupt arbitration unit.
// Assumes: vector codes are decoded by the sequencer's vector-fetch logic.
package intr_pkg;
    localparam int VEC_W = 2;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE = 2'd0,
        VEC_IRQ  = 2'd1,
        VEC_NMI  = 2'd2,
        VEC_RST  = 2'd3
    } vec_e;
endpackage

// File: rtl/nmi_edge_latch.sv
// Detects falling edges on the active-low non-maskable input and holds them
// until the arbiter selects the non-maskable vector.
// Assumes: nmi_n is already synchronous to clk.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic clr_i,
    output logic active_o
);
    logic prev_q;
    logic pend_q;
    logic fall;

    // edge of this cycle counts at once, so the window sees it without delay
    assign fall     = prev_q & ~nmi_n_i;
    assign active_o = pend_q | fall;

    // remember last level of the pin
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= nmi_n_i;
    end

    // pending flag: consumed on selection, otherwise set by an edge
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (clr_i) pend_q <= 1'b0;
        else if (fall)  pend_q <= 1'b1;
    end
endmodule

// File: rtl/sample_window.sv
// Captures the decision to interrupt at the end of each instruction.
// A normal instruction uses the request seen in its penultimate cycle; a
// conditional branch uses the request seen in its last cycle.
// Assumes: last_i and sync_i are never high in the same cycle.
module sample_window (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic last_i,
    input  logic sync_i,
    input  logic branch_i,
    output logic take_o
);
    logic req_q;
    logic take_q;

    assign take_o = take_q;

    // one-cycle history of the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_i;
    end

    // decision latched at the end of the last cycle, dropped after the fetch
    always_ff @(posedge clk) begin
        if (!rst_n)      take_q <= 1'b0;
        else if (last_i) take_q <= branch_i ? req_i : req_q;
        else if (sync_i) take_q <= 1'b0;
    end
endmodule

// File: rtl/entry_tracker.sv
// Counts the cycles of a running break entry and holds its vector code.
// Allows a maskable entry to be redirected to the non-maskable vector while
// the counter is below HIJACK_LIMIT.
// Assumes: start_i only pulses while no entry is running.
module entry_tracker
    import intr_pkg::*;
#(
    parameter int ENTRY_CYCLES = 7,
    parameter int HIJACK_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  vec_e start_vec_i,
    input  logic nmi_active_i,
    output logic active_o,
    output vec_e vec_o,
    output logic hijack_o
);
    localparam int CNT_W = $clog2(ENTRY_CYCLES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] HJ_IDX   = CNT_W'(HIJACK_LIMIT);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    vec_e             vec_q;

    assign active_o = active_q;
    assign vec_o    = vec_q;
    assign hijack_o = active_q && (vec_q == VEC_IRQ) && nmi_active_i && (cnt_q < HJ_IDX);

    // entry cycle counter; cycle 0 is the forced fetch itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(1);
        end else if (active_q) begin
            if (cnt_q == LAST_IDX) active_q <= 1'b0;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // vector held for the entry, switched once on a hijack
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_q <= VEC_NONE;
        else if (start_i)  vec_q <= start_vec_i;
        else if (hijack_o) vec_q <= VEC_NMI;
    end
endmodule

// File: rtl/intr_inject_unit.sv
// Top of the interrupt arbitration unit. Combines the requests, applies the
// sampling window, picks the vector by priority and drives the break
// injection strobe and hardware-break flag for the sequencer.
// Assumes: the sequencer runs a 7-cycle entry after force_brk_o and keeps
// last_cycle_i and sync_i low during it.
module intr_inject_unit
    import intr_pkg::*;
#(
    parameter int ENTRY_CYCLES = 7,
    parameter int HIJACK_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_reset_req_i,
    input  logic             irq_n_i,
    input  logic             nmi_n_i,
    input  logic             irq_mask_i,
    input  logic             sync_i,
    input  logic             last_cycle_i,
    input  logic             branch_i,
    output logic             force_brk_o,
    output logic [VEC_W-1:0] vec_sel_o,
    output logic             hw_brk_o
);
    logic rst_pend_q;
    logic nmi_active;
    logic nmi_clr;
    logic take;
    logic req_any;
    logic entry_active;
    logic hijack;
    vec_e entry_vec;
    vec_e start_vec;

    nmi_edge_latch nmi_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_n_i  (nmi_n_i),
        .clr_i    (nmi_clr),
        .active_o (nmi_active)
    );

    // any request that may open an entry at the next boundary
    assign req_any = rst_pend_q | nmi_active | (~irq_n_i & ~irq_mask_i);

    sample_window win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_any),
        .last_i   (last_cycle_i),
        .sync_i   (sync_i),
        .branch_i (branch_i),
        .take_o   (take)
    );

    // priority: reset, then non-maskable, then maskable
    always_comb begin
        if (rst_pend_q)      start_vec = VEC_RST;
        else if (nmi_active) start_vec = VEC_NMI;
        else                 start_vec = VEC_IRQ;
    end

    assign force_brk_o = sync_i & ~entry_active & (take | rst_pend_q);
    assign nmi_clr     = (force_brk_o & (start_vec == VEC_NMI)) | hijack;

    entry_tracker #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .HIJACK_LIMIT (HIJACK_LIMIT)
    ) trk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (force_brk_o),
        .start_vec_i  (start_vec),
        .nmi_active_i (nmi_active),
        .active_o     (entry_active),
        .vec_o        (entry_vec),
        .hijack_o     (hijack)
    );

    // reset pending: armed by unit reset or a request, consumed on selection
    always_ff @(posedge clk) begin
        if (!rst_n)                                     rst_pend_q <= 1'b1;
        else if (cpu_reset_req_i)                       rst_pend_q <= 1'b1;
        else if (force_brk_o && start_vec == VEC_RST)   rst_pend_q <= 1'b0;
    end

    // output code: live choice in the forced cycle, held code afterwards
    always_comb begin
        if (force_brk_o)       vec_sel_o = start_vec;
        else if (entry_active) vec_sel_o = entry_vec;
        else                   vec_sel_o = VEC_NONE;
    end

    assign hw_brk_o = force_brk_o | entry_active;
endmodule

// File: rtl/intr_inject_chk.sv
// Property checker for intr_inject_unit, attached by bind.
// Assumes: the sequencer obeys the entry length contract.
module intr_inject_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_reset_req_i,
    input logic       force_brk_o,
    input logic [1:0] vec_sel_o,
    input logic       hw_brk_o
);
    AST_FORCE_OPENS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        force_brk_o |=> (hw_brk_o && !force_brk_o));                        // R2

    AST_IDLE_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_brk_o |-> (vec_sel_o == 2'd0));                                 // R3

    AST_FORCE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        force_brk_o |-> (vec_sel_o != 2'd0));                               // R1

    AST_CODE_ONLY_HIJACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_brk_o && !force_brk_o && $past(hw_brk_o)) |->
        ((vec_sel_o == $past(vec_sel_o)) ||
         ($past(vec_sel_o) == 2'd1 && vec_sel_o == 2'd2)));                 // R11

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_brk_o && $past(cpu_reset_req_i)) |-> (vec_sel_o == 2'd3));   // R10
endmodule

bind intr_inject_unit intr_inject_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_reset_req_i (cpu_reset_req_i),
    .force_brk_o     (force_brk_o),
    .vec_sel_o       (vec_sel_o),
    .hw_brk_o        (hw_brk_o)
);

// File: tb/intr_inject_unit_tb_top.sv
module intr_inject_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rreq = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, imask = 1'b0;
    logic       sync = 1'b0, last = 1'b0, br = 1'b0;
    logic       force_brk;
    logic [1:0] vec;
    logic       hw;
    int         errors = 0, checks = 0;

    always #10 clk = ~clk;

    intr_inject_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_reset_req_i(rreq), .irq_n_i(irq_n),
        .nmi_n_i(nmi_n), .irq_mask_i(imask), .sync_i(sync), .last_cycle_i(last),
        .branch_i(br), .force_brk_o(force_brk), .vec_sel_o(vec), .hw_brk_o(hw)
    );

    // columns: len, branch, mask, irq_from, nmi_at, exp_force, exp_vec, req
    localparam int NCASE = 11;
    localparam int TAB [NCASE][8] = '{
        '{4, 0, 0, -1, -1, 0, 0, 3},   // R3 nothing pending
        '{4, 0, 0,  2, -1, 1, 1, 4},   // R4 penultimate irq
        '{4, 0, 0,  3, -1, 0, 0, 6},   // R6 too late
        '{4, 0, 1,  0, -1, 0, 0, 5},   // R5 masked
        '{3, 1, 0,  2, -1, 1, 1, 7},   // R7 branch, last-cycle irq
        '{3, 1, 0, -1,  2, 1, 2, 7},   // R7 branch, last-cycle nmi
        '{5, 0, 1, -1,  1, 1, 2, 8},   // R8 nmi ignores mask
        '{5, 0, 0,  1,  1, 1, 2, 10},  // R10 nmi beats irq
        '{2, 0, 0,  0, -1, 1, 1, 4},   // R4 two-cycle instruction
        '{6, 0, 0, -1,  4, 1, 2, 8},   // R8 pulse in penultimate
        '{7, 0, 0, -1, -1, 0, 0, 3}    // R3 long instruction
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge and settle before sampling
    task automatic drive(input bit s, input bit l, input bit b, input bit m,
                         input bit irq_low, input bit nmi_low, input bit rr);
        @(negedge clk);
        sync = s; last = l; br = b; imask = m;
        irq_n = ~irq_low; nmi_n = ~nmi_low; rreq = rr;
        #2;
    endtask

    task automatic entry_body(input int code, input string tag);
        for (int e = 1; e < 7; e++) begin
            drive(0, 0, 0, 0, 0, 0, 0);
            chk({tag, " entry hw"}, hw, 1);
            chk({tag, " entry code"}, vec, code);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state and reset entry
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 idle force", force_brk, 0);
        chk("R1 idle hw", hw, 0);
        chk("R1 idle code", vec, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R1 force", force_brk, 1);
        chk("R1 code", vec, 3);
        entry_body(3, "R2");

        // table walk
        for (int k = 0; k < NCASE; k++) begin
            for (int c = 0; c < TAB[k][0]; c++) begin
                drive(c == 0, c == TAB[k][0] - 1, TAB[k][1] != 0, TAB[k][2] != 0,
                      TAB[k][3] >= 0 && c >= TAB[k][3], TAB[k][4] == c, 0);
                if (c == 0) begin
                    chk("R3 quiet fetch", force_brk, 0);
                    chk("R2 entry ended", hw, 0);
                end
            end
            drive(1, 0, 0, 0, 0, 0, 0);
            chk($sformatf("R%0d force case %0d", TAB[k][7], k), force_brk, TAB[k][5]);
            chk($sformatf("R%0d code case %0d", TAB[k][7], k), vec, TAB[k][6]);
            if (TAB[k][5] != 0) entry_body(TAB[k][6], "R2");
            else drive(0, 1, 0, 0, 0, 0, 0);
        end

        // R6: late irq held is taken one instruction later
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 1, 0, 0);
        chk("R6 not at first boundary", force_brk, 0);
        drive(0, 1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R6 taken next boundary", force_brk, 1);
        chk("R6 code", vec, 1);
        entry_body(1, "R6");

        // R11: early hijack redirects to code 2 and consumes the request
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        drive(0, 1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R11 irq entry", vec, 1);
        for (int e = 1; e < 7; e++) begin
            drive(0, 0, 0, 0, 0, e == 3, 0);
            chk("R11 hijack code", vec, (e <= 3) ? 1 : 2);
        end
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R9 hijacked nmi consumed", force_brk, 0);
        drive(0, 1, 0, 0, 0, 0, 0);

        // R11: late edge keeps code 1 and waits for the next boundary
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        drive(0, 1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        for (int e = 1; e < 7; e++) begin
            drive(0, 0, 0, 0, 0, e == 5, 0);
            chk("R11 late edge keeps code", vec, 1);
        end
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R11 deferred nmi not early", force_brk, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R11 deferred nmi force", force_brk, 1);
        chk("R11 deferred nmi code", vec, 2);
        entry_body(2, "R11");

        // R9: nmi held low does not retrigger
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        drive(0, 1, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 1, 0);
        chk("R9 first nmi", vec, 2);
        for (int e = 1; e < 7; e++) drive(0, 0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 1, 0);
        drive(0, 1, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 1, 0);
        chk("R9 no retrigger", force_brk, 0);
        chk("R9 no code", vec, 0);
        drive(0, 1, 0, 0, 0, 0, 0);

        // R12 and R10: reset pulse beats a pending irq
        drive(1, 0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 1, 0, 0);
        drive(0, 1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R12 reset request force", force_brk, 1);
        chk("R10 reset priority code", vec, 3);
        entry_body(3, "R12");
        drive(1, 0, 0, 0, 0, 0, 0);
        chk("R12 reset consumed", force_brk, 0);

        finish_run();
    end
endmodule